// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(4096). The larger field is built as a degree-two extension over GF(64), not as one field reduced by a degree-12 polynomial. Each operand is cut into a 6-bit upper half and a 6-bit lower half, and both halves are treated as GF(64) elements. Three base-field products are taken, plus one product by a fixed extension constant. These are then combined with XOR to form the two halves of the result.

A second mode, selected by `step_i`, advances a running root power. In this mode the block ignores `b_i` and multiplies `a_i` by the fixed generator constant. The zero element is a special case: it steps to one. A decoder or sequencer can feed the output back into `a_i` to walk through every non-zero element of the field in turn. When the `OUT_REG` parameter is set, a single output register follows the multiplier. With the default setting, a result appears one clock after its valid input. With `OUT_REG` cleared, the path is purely combinational.

Top module: `gf4096_tower_mul`

## Requirements
- R1: An element's bits [11:6] form its upper half h and bits [5:0] its lower half l. The product of (ah,al) and (bh,bl) has upper half (ah^al)*(bh^bl) ^ al*bl and lower half 0x21*ah*bh ^ al*bl, where * is GF(64) multiplication and ^ is XOR.
- R2: GF(64) multiplication reduces by x^6 + x + 1: a carry out of bit 5 folds back as XOR with 0x03. With both upper halves zero, the product equals {6'h00, al*bl}.
- R3: With both lower halves zero, the product equals {ah*bh, 0x21*(ah*bh)}, which applies the extension constant 0x21.
- R4: With `step_i`=1, the result is 0x001 when `a_i` is 0, and `a_i`*0xE01 (per R1) otherwise. `b_i` has no effect on the result.
- R5: Starting at 0x001, repeated stepping with the output fed back first returns to 0x001 after exactly 4095 steps.
- R6: In multiply mode, a zero operand gives 0x000, and an operand of 0x001 gives the other operand unchanged.
- R7: The product is commutative: swapping `a_i` and `b_i` gives the same result.
- R8: With `OUT_REG`=1, `valid_o` and `prod_o` update on the rising edge after the edge that samples `valid_i`=1. `valid_o` is low on the edge after a cycle with `valid_i`=0.
- R9: While `valid_i` is low, `prod_o` holds its last value.
- R10: While `rst_ni` is low, `valid_o` is 0 and `prod_o` is 0x000, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| step_i | input | 1 | 1: generator step on a_i; 0: multiply a_i by b_i |
| a_i | input | 12 | First operand / current root power |
| b_i | input | 12 | Second operand, ignored in step mode |
| valid_o | output | 1 | Result valid |
| prod_o | output | 12 | Product or next root power |

## Verification
The bench sweeps every 64x64 pair confined to the lower halves and every pair confined to the upper halves. A wrong base reduction polynomial shows up in the first sweep, and a wrong or missing extension constant in the second. Full 4096-value sweeps against zero and one catch a half that is swapped or dropped. Random pairs taken in both orders catch mixing that treats the two operands unequally.

The stepping chain is run for a full 4095 cycles with the output fed back, and the bench records the first return to one. A wrong generator constant shows up as a short cycle or as no return at all. A missing zero-to-one rule leaves the chain stuck at zero. Scoreboard timing checks catch a result that arrives one cycle early or late, and an output that drifts while `valid_i` is low.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
  localparam int unsigned HALF_W = 6;
  localparam int unsigned ELEM_W = 2 * HALF_W;

  // x^6 = x + 1 : folded low bits of the base polynomial
  localparam logic [HALF_W-1:0] BASE_POLY_LO = 6'h03;
  // y^2 + y + k, k selected so that 0x21 is the needed GF(64) factor
  localparam logic [HALF_W-1:0] EXT_K        = 6'h21;
  localparam logic [ELEM_W-1:0] STEP_K       = 12'hE01;
  localparam logic [ELEM_W-1:0] ELEM_ONE     = 12'h001;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [ELEM_W-1:0] elem_t;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
  parameter int unsigned     W       = 6,
  parameter logic [W-1:0]    POLY_LO = 6'h03
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);

  function automatic logic [W-1:0] xtime(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ ({W{v[W-1]}} & POLY_LO);
  endfunction

  // fully unrolled shift-and-add
  always_comb begin
    logic [W-1:0] acc;
    logic [W-1:0] sh;
    acc = '0;
    sh  = b_i;
    for (int i = 0; i < int'(W); i++) begin
      acc = acc ^ ({W{a_i[i]}} & sh);
      sh  = xtime(sh);
    end
    p_o = acc;
  end

  always_comb begin
    AST_BASE_ZERO: assert ((a_i != '0 && b_i != '0) || p_o == '0); // R2
  end

endmodule

// File: rtl/gf4096_mul.sv
module gf4096_mul #(
  parameter int unsigned          HALF_W  = 6,
  parameter logic [HALF_W-1:0]    POLY_LO = 6'h03,
  parameter logic [HALF_W-1:0]    EXT_K   = 6'h21,
  localparam int unsigned         ELEM_W  = 2 * HALF_W
) (
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  output logic [ELEM_W-1:0] p_o
);

  logic [HALF_W-1:0] ah, al, bh, bl;
  logic [HALF_W-1:0] sum_a, sum_b;
  logic [HALF_W-1:0] p_mid, p_lo, p_hi, p_hik;

  assign ah    = a_i[ELEM_W-1:HALF_W];
  assign al    = a_i[HALF_W-1:0];
  assign bh    = b_i[ELEM_W-1:HALF_W];
  assign bl    = b_i[HALF_W-1:0];
  assign sum_a = ah ^ al;
  assign sum_b = bh ^ bl;

  gf64_mul #(.W(HALF_W), .POLY_LO(POLY_LO)) u_mid (
    .a_i(sum_a), .b_i(sum_b), .p_o(p_mid)
  );
  gf64_mul #(.W(HALF_W), .POLY_LO(POLY_LO)) u_lo (
    .a_i(al), .b_i(bl), .p_o(p_lo)
  );
  gf64_mul #(.W(HALF_W), .POLY_LO(POLY_LO)) u_hi (
    .a_i(ah), .b_i(bh), .p_o(p_hi)
  );
  // fixed-operand instance: constant propagation reduces it to an XOR net
  gf64_mul #(.W(HALF_W), .POLY_LO(POLY_LO)) u_ext (
    .a_i(p_hi), .b_i(EXT_K), .p_o(p_hik)
  );

  assign p_o = {p_mid ^ p_lo, p_hik ^ p_lo};

  always_comb begin
    AST_EXT_ZERO: assert ((a_i != '0 && b_i != '0) || p_o == '0); // R6
  end

endmodule

// File: rtl/gf_step_ctrl.sv
module gf_step_ctrl
  import gf_tower_pkg::*;
#(
  parameter elem_t STEP_MUL = STEP_K
) (
  input  logic  step_i,
  input  elem_t a_i,
  input  elem_t b_i,
  input  elem_t raw_i,
  output elem_t op_b_o,
  output elem_t res_o
);

  logic step_zero;

  assign step_zero = step_i && (a_i == '0);
  assign op_b_o    = step_i ? STEP_MUL : b_i;
  // 0 is not a power of the generator; restart the walk at 1
  assign res_o     = step_zero ? ELEM_ONE : raw_i;

endmodule

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul
  import gf_tower_pkg::*;
#(
  parameter bit    OUT_REG  = 1'b1,
  parameter elem_t STEP_MUL = STEP_K
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              step_i,
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  output logic              valid_o,
  output logic [ELEM_W-1:0] prod_o
);

  elem_t op_b, raw, res;

  gf_step_ctrl #(.STEP_MUL(STEP_MUL)) u_ctrl (
    .step_i (step_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .raw_i  (raw),
    .op_b_o (op_b),
    .res_o  (res)
  );

  gf4096_mul #(
    .HALF_W  (HALF_W),
    .POLY_LO (BASE_POLY_LO),
    .EXT_K   (EXT_K)
  ) u_mul (
    .a_i (a_i),
    .b_i (op_b),
    .p_o (raw)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic  vld_q;
      elem_t prod_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q  <= 1'b0;
          prod_q <= '0;
        end else begin
          vld_q <= valid_i;
          if (valid_i) prod_q <= res;
        end
      end

      assign valid_o = vld_q;
      assign prod_o  = prod_q;

      AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o); // R8
      AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o); // R8
      AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(prod_o)); // R9
      AST_STEP_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && step_i) |=> prod_o != '0); // R4
      AST_ZERO_ABSORB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !step_i && (a_i == '0 || b_i == '0)) |=> prod_o == '0); // R6
      AST_UNIT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !step_i && a_i == ELEM_ONE) |=> prod_o == $past(b_i)); // R6
    end else begin : g_comb
      assign valid_o = valid_i;
      assign prod_o  = res;

      always_comb begin
        AST_COMB_UNIT: assert (!(valid_i && !step_i && a_i == ELEM_ONE) || prod_o == b_i); // R6
      end
    end
  endgenerate

endmodule

// File: tb/test_gf4096_tower_mul.sv
module test_gf4096_tower_mul;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, step_i;
  logic [11:0] a_i, b_i;
  logic        valid_o;
  logic [11:0] prod_o;

  always #10 clk = ~clk; // 50 MHz

  gf4096_tower_mul i_gf4096_tower_mul (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_i),
    .step_i  (step_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (valid_o),
    .prod_o  (prod_o)
  );

  typedef struct {
    logic [11:0] exp;
    string       tag;
    int          cyc;
  } item_t;

  item_t sbq[$];
  int    errors = 0;
  int    checks = 0;
  int    cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bit-serial base-field reference, 7-bit shift register with fold on bit 6
  function automatic logic [5:0] ref_gf64(input logic [5:0] a, input logic [5:0] b);
    logic [6:0] bb;
    logic [5:0] c;
    c  = '0;
    bb = {1'b0, b};
    for (int i = 0; i < 6; i++) begin
      if (a[i]) c = c ^ bb[5:0];
      bb = bb << 1;
      if (bb[6]) bb = bb ^ 7'h43;
    end
    return c;
  endfunction

  function automatic logic [11:0] ref_mul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] hi, lo;
    hi = ref_gf64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ ref_gf64(a[5:0], b[5:0]);
    lo = ref_gf64(ref_gf64(a[11:6], b[11:6]), 6'h21) ^ ref_gf64(a[5:0], b[5:0]);
    return {hi, lo};
  endfunction

  function automatic logic [11:0] ref_step(input logic [11:0] a);
    return (a == 12'h000) ? 12'h001 : ref_mul(a, 12'hE01);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // monitor: pops due items as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (sbq.size() > 0 && sbq[0].cyc < cyc) begin
        item_t it;
        it = sbq.pop_front();
        if (!valid_o) check(1'b0, {it.tag, " R8 missing valid"}, prod_o, it.exp);
        else          check(prod_o === it.exp, it.tag, prod_o, it.exp);
      end else if (valid_o) begin
        check(1'b0, "R8 spurious valid", prod_o, 12'h000);
      end
    end
  end

  task automatic drive(input bit st, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] exp, input string tag);
    item_t it;
    valid_i = 1'b1;
    step_i  = st;
    a_i     = a;
    b_i     = b;
    it.exp  = exp;
    it.tag  = tag;
    it.cyc  = cyc;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    a_i     = 12'(n * 37);
    b_i     = 12'(n * 91);
    step_i  = n[0];
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<200000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] cur, ra, rb, hold_val;
    int          period;

    rst_n   = 1'b0;
    valid_i = 1'b1;
    step_i  = 1'b0;
    a_i     = 12'h5A5;
    b_i     = 12'h3C3;
    repeat (3) @(negedge clk);
    // R10: reset holds outputs at zero despite active inputs
    check(valid_o === 1'b0, "R10 valid_o", {11'h0, valid_o}, 12'h000);
    check(prod_o === 12'h000, "R10 prod_o", prod_o, 12'h000);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: zero and unit operands, full sweep
    for (int v = 0; v < 4096; v++) begin
      drive(1'b0, 12'(v), 12'h000, 12'h000, "R6 a*0");
      drive(1'b0, 12'h000, 12'(v), 12'h000, "R6 0*b");
      drive(1'b0, 12'(v), 12'h001, 12'(v), "R6 a*1");
      drive(1'b0, 12'h001, 12'(v), 12'(v), "R6 1*b");
    end

    // R2: lower halves only -> pure base field product
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        drive(1'b0, 12'(x), 12'(y), {6'h00, ref_gf64(6'(x), 6'(y))}, "R2 low-half");

    // R3: upper halves only -> extension constant in lower half
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++) begin
        logic [5:0] p;
        p = ref_gf64(6'(x), 6'(y));
        drive(1'b0, {6'(x), 6'h00}, {6'(y), 6'h00}, {p, ref_gf64(p, 6'h21)}, "R3 high-half");
      end

    // R7: commutativity on random pairs
    for (int n = 0; n < 2000; n++) begin
      ra = 12'($urandom);
      rb = 12'($urandom);
      drive(1'b0, ra, rb, ref_mul(ra, rb), "R7 a*b");
      drive(1'b0, rb, ra, ref_mul(ra, rb), "R7 b*a");
    end

    // R1: general random products
    for (int n = 0; n < 20000; n++) begin
      ra = 12'($urandom);
      rb = 12'($urandom);
      drive(1'b0, ra, rb, ref_mul(ra, rb), "R1 random");
    end

    // R4: zero steps to one; b ignored
    drive(1'b1, 12'h000, 12'hFFF, 12'h001, "R4 step zero");
    drive(1'b1, 12'h000, 12'h000, 12'h001, "R4 step zero b0");
    drive(1'b1, 12'h001, 12'h123, 12'hE01, "R4 step one");

    // R5: walk the powers with feedback
    cur    = 12'h001;
    period = 0;
    for (int n = 1; n <= 4095; n++) begin
      drive(1'b1, cur, 12'($urandom), ref_step(cur), "R4 step chain");
      cur = prod_o;
      if (cur == 12'h001 && period == 0) period = n;
    end
    check(period == 4095, "R5 period", 12'(period), 12'(4095));

    // R8/R9: latency and hold while idle
    ra = 12'h7B3;
    rb = 12'h2E9;
    hold_val = ref_mul(ra, rb);
    drive(1'b0, ra, rb, hold_val, "R8 single");
    idle(4);
    check(valid_o === 1'b0, "R9 valid low", {11'h0, valid_o}, 12'h000);
    check(prod_o === hold_val, "R9 hold", prod_o, hold_val);

    idle(2);
    check(sbq.size() == 0, "R8 drained", 12'(sbq.size()), 12'h000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule